// File: doc/BRIEF.md
# Write Leveling Exit Sequencer

This controller-side state machine takes one memory rank out of write leveling and back to normal operation. A leveling engine pulses `start` once it has sent its last DQS pulse. The sequencer then steps through a fixed order:

1. It keeps DQS driven while the leveling feedback settles, and strobes the capture of the final DQ result.
2. It releases DQS and pulls ODT low.
3. It waits out the ODT-off latency and the worst-case termination-off time.
4. It issues a single mode register write to MR1. The written value has the leveling enable bit cleared.
5. It times two separate windows after that write: one for further mode register writes, and one for any command.

Every interval is a cycle count taken from a configuration input. A count of zero is treated as one. The configuration inputs must be held stable while a sequence runs. The command bus carries `{ras_n, cas_n, we_n}`. NOP is 3'b111 and MRS is 3'b000.

Top module: `wl_exit_seq`

## Requirements
- R1: Reset is synchronous and active high, and the idle state matches it. In idle, `dqs_oe`=0, `odt`=0, `cmd`=3'b111, `ba`=0, `addr`=0, `dq_capture`=0 and `done`=0, while `mrs_ok`=1 and `cmd_ok`=1. A reset in the middle of a sequence returns the block to idle, and the sequence does not resume afterwards.
- R2: Let W be the output-delay count and M the margin count. Start is sampled at an edge, and cycle 1 is the cycle after that edge. `dqs_oe` and `odt` are both 1 in cycles 1 to W+M. Both are 0 from cycle W+M+1 on, so ODT drops in the same cycle that DQS is released.
- R3: `dq_capture` is 1 for exactly one cycle. That cycle is W+M, the last cycle in which DQS is still driven.
- R4: Let L be the ODT-off latency count and A the termination-off count. With T = W+M+L+A+1, the MRS command (`cmd`=3'b000) appears in cycle T only. In that cycle `ba`=3'b001, and `addr` equals `mr1_image` with bit 7 forced to 0.
- R5: In every other cycle, `cmd`=3'b111, `ba`=0 and `addr`=0.
- R6: During the sequence `mrs_ok` is 0. It becomes 1 in cycle T+Rm, where Rm is the tMRD count.
- R7: `done` is 1 only in cycle T+Dm, where Dm is the tMOD count. `cmd_ok` is 0 during the sequence and is 1 from cycle T+Dm on, when the block is idle again.
- R8: A count input of zero acts as one. A tMRD count greater than the tMOD count acts as the tMOD count.
- R9: A `start` pulse that arrives while a sequence is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | last leveling DQS pulse sent; begin exit |
| cfg_wlo | input | CW | write-leveling output delay, cycles |
| cfg_margin | input | CW | capture margin, cycles |
| cfg_odtloff | input | CW | ODT-off latency, cycles |
| cfg_aof | input | CW | maximum termination-off time, cycles |
| cfg_mrd | input | CW | MRS-to-MRS window, cycles |
| cfg_mod | input | CW | MRS-to-any-command window, cycles |
| mr1_image | input | AW | stored MR1 value |
| dqs_oe | output | 1 | DQS output enable |
| odt | output | 1 | ODT pin level |
| cmd | output | 3 | {ras_n, cas_n, we_n} |
| ba | output | BW | bank address / mode register select |
| addr | output | AW | address / mode register data |
| dq_capture | output | 1 | strobe to capture final DQ result |
| done | output | 1 | one-cycle completion pulse |
| mrs_ok | output | 1 | another MRS may be issued |
| cmd_ok | output | 1 | any command may be issued |

## Verification
The bench sweeps every small combination of the six counts, including zeros and a tMRD count larger than the tMOD count. It checks every output in every cycle of each sequence against a timeline computed in the bench.

Each check targets a specific fault:
- An off-by-one in any counter would shift the DQS release, the MRS cycle or a permission flag by one cycle.
- Dropping ODT late would show `odt` high after DQS is released.
- Forgetting to clear bit 7 would show up in the MR1 address value.
- Missing the zero clamp would stall the counters, or wrap them around.

Restart pulses are sent in the middle of some sequences, and a reset is applied mid-sequence. These catch a design that reloads its counters on a stray start or resumes after a reset.

// File: rtl/wl_exit_seq.sv
module wl_exit_seq #(
  parameter int CW  = 8,
  parameter int AW  = 14,
  parameter int BW  = 3,
  parameter int WLB = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_wlo,
  input  logic [CW-1:0] cfg_margin,
  input  logic [CW-1:0] cfg_odtloff,
  input  logic [CW-1:0] cfg_aof,
  input  logic [CW-1:0] cfg_mrd,
  input  logic [CW-1:0] cfg_mod,
  input  logic [AW-1:0] mr1_image,
  output logic          dqs_oe,
  output logic          odt,
  output logic [2:0]    cmd,
  output logic [BW-1:0] ba,
  output logic [AW-1:0] addr,
  output logic          dq_capture,
  output logic          done,
  output logic          mrs_ok,
  output logic          cmd_ok
);

  localparam logic [2:0]    CMD_NOP = 3'b111;
  localparam logic [2:0]    CMD_MRS = 3'b000;
  localparam logic [BW-1:0] BA_MR1  = BW'(1);
  localparam logic [AW-1:0] WL_MASK = ~(AW'(1) << WLB);
  localparam logic [CW-1:0] ONE     = CW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_MARG, S_ODTL, S_AOF, S_MRS, S_POST
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, el;

  function automatic logic [CW-1:0] atleast1(input logic [CW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CW-1:0] wlo_e, mar_e, odl_e, aof_e, mod_e, mrd_e, mrd_1;

  assign wlo_e = atleast1(cfg_wlo);
  assign mar_e = atleast1(cfg_margin);
  assign odl_e = atleast1(cfg_odtloff);
  assign aof_e = atleast1(cfg_aof);
  assign mod_e = atleast1(cfg_mod);
  assign mrd_1 = atleast1(cfg_mrd);
  assign mrd_e = (mrd_1 > mod_e) ? mod_e : mrd_1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      el   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st  <= S_HOLD;
            cnt <= wlo_e - ONE;
          end
        S_HOLD:
          if (cnt == '0) begin
            st  <= S_MARG;
            cnt <= mar_e - ONE;
          end else cnt <= cnt - ONE;
        S_MARG:
          if (cnt == '0) begin
            st  <= S_ODTL;
            cnt <= odl_e - ONE;
          end else cnt <= cnt - ONE;
        S_ODTL:
          if (cnt == '0) begin
            st  <= S_AOF;
            cnt <= aof_e - ONE;
          end else cnt <= cnt - ONE;
        S_AOF:
          if (cnt == '0) st <= S_MRS;
          else cnt <= cnt - ONE;
        S_MRS: begin
          el <= ONE;
          if (mod_e == ONE) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else st <= S_POST;
        end
        S_POST:
          if (el == mod_e - ONE) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else el <= el + ONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dqs_oe     = (st == S_HOLD) || (st == S_MARG);
  assign odt        = dqs_oe;
  assign dq_capture = (st == S_MARG) && (cnt == '0);
  assign cmd        = (st == S_MRS) ? CMD_MRS : CMD_NOP;
  assign ba         = (st == S_MRS) ? BA_MR1 : '0;
  assign addr       = (st == S_MRS) ? (mr1_image & WL_MASK) : '0;
  assign cmd_ok     = (st == S_IDLE);
  assign mrs_ok     = (st == S_IDLE) || ((st == S_POST) && (el >= mrd_e));

endmodule

// File: rtl/wl_exit_chk.sv
module wl_exit_chk (
  input logic       clk,
  input logic       rst,
  input logic       dqs_oe,
  input logic       odt,
  input logic [2:0] cmd,
  input logic       dq_capture,
  input logic       done,
  input logic       mrs_ok,
  input logic       cmd_ok
);

  a_r3_capture_while_driven: assert property (@(posedge clk) disable iff (rst)
    dq_capture |-> dqs_oe);

  a_r3_release_after_capture: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_oe) |-> ($past(dq_capture) || $past(rst)));

  a_r2_odt_with_dqs: assert property (@(posedge clk) disable iff (rst)
    dqs_oe |-> odt);

  a_r4_mrs_single: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b000) |=> (cmd == 3'b111));

  a_r4_mrs_after_release: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b000) |-> (!dqs_oe && !odt && !mrs_ok && !cmd_ok));

  a_r5_cmd_legal: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b000) || (cmd == 3'b111));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_opens_bus: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd_ok && mrs_ok));

  a_r6_mrs_before_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> mrs_ok);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!dqs_oe && !odt && (cmd == 3'b111) && !done && cmd_ok));

endmodule

bind wl_exit_seq wl_exit_chk u_chk (
  .clk(clk), .rst(rst), .dqs_oe(dqs_oe), .odt(odt), .cmd(cmd),
  .dq_capture(dq_capture), .done(done), .mrs_ok(mrs_ok), .cmd_ok(cmd_ok)
);

// File: tb/sim_wl_exit_seq.sv
module sim_wl_exit_seq;
  localparam int PERIOD = 10;
  localparam int CW = 8, AW = 14, BW = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] cfg_wlo = '0, cfg_margin = '0, cfg_odtloff = '0;
  logic [CW-1:0] cfg_aof = '0, cfg_mrd = '0, cfg_mod = '0;
  logic [AW-1:0] mr1_image = '0;
  logic dqs_oe, odt, dq_capture, done, mrs_ok, cmd_ok;
  logic [2:0] cmd;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0, errs = 0;

  always #(PERIOD/2) clk = ~clk;

  wl_exit_seq #(.CW(CW), .AW(AW), .BW(BW)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_wlo(cfg_wlo), .cfg_margin(cfg_margin), .cfg_odtloff(cfg_odtloff),
    .cfg_aof(cfg_aof), .cfg_mrd(cfg_mrd), .cfg_mod(cfg_mod),
    .mr1_image(mr1_image), .dqs_oe(dqs_oe), .odt(odt), .cmd(cmd), .ba(ba),
    .addr(addr), .dq_capture(dq_capture), .done(done), .mrs_ok(mrs_ok),
    .cmd_ok(cmd_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " dqs_oe"}, int'(dqs_oe), 0);
    chk({tag, " odt"}, int'(odt), 0);
    chk({tag, " cmd"}, int'(cmd), 7);
    chk({tag, " ba"}, int'(ba), 0);
    chk({tag, " addr"}, int'(addr), 0);
    chk({tag, " cap"}, int'(dq_capture), 0);
    chk({tag, " done"}, int'(done), 0);
    chk({tag, " mrs_ok"}, int'(mrs_ok), 1);
    chk({tag, " cmd_ok"}, int'(cmd_ok), 1);
  endtask

  function automatic int e1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run(input int w, input int m, input int l, input int a,
                     input int rd, input int md, input int img, input bit restart);
    int we, me, le, ae, de, re, t;
    we = e1(w); me = e1(m); le = e1(l); ae = e1(a); de = e1(md);
    re = e1(rd); if (re > de) re = de;   // R8 clamp
    t = we + me + le + ae + 1;
    cfg_wlo = CW'(w); cfg_margin = CW'(m); cfg_odtloff = CW'(l);
    cfg_aof = CW'(a); cfg_mrd = CW'(rd); cfg_mod = CW'(md);
    mr1_image = AW'(img);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 1; k <= t + de + 2; k++) begin
      chk("R2 dqs_oe", int'(dqs_oe), int'(k <= we + me));
      chk("R2 odt", int'(odt), int'(k <= we + me));
      chk("R3 dq_capture", int'(dq_capture), int'(k == we + me));
      if (k == t) begin
        chk("R4 cmd", int'(cmd), 0);
        chk("R4 ba", int'(ba), 1);
        chk("R4 addr", int'(addr), img & 16'h3F7F);
      end else begin
        chk("R5 cmd", int'(cmd), 7);
        chk("R5 ba", int'(ba), 0);
        chk("R5 addr", int'(addr), 0);
      end
      chk("R6 R8 mrs_ok", int'(mrs_ok), int'(k >= t + re));
      chk("R7 cmd_ok", int'(cmd_ok), int'(k >= t + de));
      chk("R7 done", int'(done), int'(k == t + de));
      if (restart && k == 2) start = 1'b1;   // R9 stray start
      if (k == 3) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 reset");
    for (int w = 0; w <= 3; w++)
      for (int m = 1; m <= 2; m++)
        for (int l = 0; l <= 2; l++)
          for (int a = 1; a <= 2; a++)
            for (int p = 0; p < 4; p++) begin
              int rd, md;
              rd = (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 5 : 0;
              md = (p == 0) ? 1 : (p == 1) ? 4 : (p == 2) ? 2 : 3;
              run(w, m, l, a, rd, md, (n * 1237 + 16'h0A5) & 16'h3FFF, n[0]);
              n++;
            end
    chk_idle("R1 idle after sweep");
    run(0, 0, 0, 0, 0, 0, 16'h3FFF, 1'b1);   // R8 all-zero counts
    cfg_wlo = 8'd3; cfg_margin = 8'd3; cfg_odtloff = 8'd2; cfg_aof = 8'd2;
    cfg_mrd = 8'd2; cfg_mod = 8'd4;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 mid-run dqs_oe", int'(dqs_oe), 1);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      chk_idle("R1 after mid-run reset");
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL R7 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule